// File: doc/BRIEF.md
# Sector Symbol-Error Patch Engine

This block repairs one sector of a page buffer after a 4-symbol error-correcting decoder has finished with it. The decoder leaves up to four result words in a bank of registers. Each word names a byte inside the 512-byte sector and gives the bit pattern that repairs it. A word that still holds its reset value means "nothing found". When the decoder raises its end indication, the engine walks the bank. For each live word it reads the addressed byte from a single-port byte RAM, XORs in the pattern, and writes the byte back. When the walk is over it strobes a clear back to the decoder. Each sector of data carries ten check bytes and can be repaired in at most four symbols.

The buffer address depends on the page organisation. With large pages a page holds four sectors, and the sector number selects a 512-byte window of the buffer. With small pages the in-sector offset is the whole address. The engine remembers, for each slot, whether it has already been applied. If the decoder signals the end more than once for the same sector, no byte is flipped twice. The memory is cleared when the next sector is announced. If the decoder flags the sector as beyond repair, the engine marks the sector failed and touches nothing. While `busy` is high the engine owns the RAM port, and the surrounding logic must keep the host off the buffer.

Top module: `ecc_patch`

## Requirements
- R1: After reset `busy`, `ramRe`, `ramWe`, `decClear`, `passDone` and `sectorFail` are all 0.
- R2: A result slot equal to `EMPTY_VAL` (default 32'h0000_0000) causes no RAM read and no RAM write. A pass over a bank with only such slots writes nothing but still completes with `decClear` and `passDone`.
- R3: Slot g sits in `resultBank[g*32 +: 32]`. Bits 24:16 of a slot give the byte offset inside the sector (bits 31:25 must be zero). Bits 7:0 give the pattern. The byte written back equals the byte read XOR the pattern.
- R4: With `largePage`=1 the RAM address is `sectorIdx`*512 + offset. With `largePage`=0 it is the offset alone. `sectorIdx` and `largePage` are sampled when the pass is accepted.
- R5: Each live slot costs exactly two cycles: a read cycle (`ramRe`=1, address driven), then a write cycle (`ramWe`=1, same address). Live slots are handled from the lowest index upward. The RAM returns read data one cycle after the address.
- R6: A slot is applied at most once between two `sectorStart` pulses. A repeated `decEnd` for the same sector causes no write for slots already applied.
- R7: `sectorStart` in idle clears every slot's applied mark and `sectorFail`, so the same bank is applied again after it.
- R8: `decFail` in idle sets `sectorFail`, gives a one-cycle `decClear` without `passDone`, and writes nothing. `decFail` wins over a `decEnd` in the same cycle. While `sectorFail` is set, `decEnd` is ignored.
- R9: A pass starts only on `decEnd` in idle (the first read cycle follows that edge). After the last slot, one extra select cycle follows, and then one cycle with `decClear`=1 and `passDone`=1. `busy` falls the cycle after that.
- R10: While `busy` is 1, `sectorStart`, `decEnd` and `decFail` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sectorStart | input | 1 | New sector announced; clears applied marks and fail |
| sectorIdx | input | SEC_W (2) | Sector number within a large page |
| largePage | input | 1 | 1 selects the large-page address form |
| resultBank | input | SLOTS*32 (128) | Decoder result words, slot 0 in the low bits |
| decEnd | input | 1 | Decoder finished with the sector |
| decFail | input | 1 | Decoder reports the sector uncorrectable |
| decClear | output | 1 | One-cycle clear of the decoder's control/status |
| passDone | output | 1 | One-cycle marker of a completed correction pass |
| sectorFail | output | 1 | Sector marked uncorrectable |
| busy | output | 1 | Engine owns the buffer RAM port |
| ramRe | output | 1 | RAM read enable |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | ADDR_W (11) | RAM byte address |
| ramWdata | output | 8 | Repaired byte |
| ramRdata | input | 8 | RAM read data, one cycle after the address |

## Verification
Every cycle the checker verifies the shape of the read-modify-write traffic. Each write follows a read at the same address. No RAM access happens outside `busy` or on a failed sector. The clear strobe lasts exactly one cycle, and no pass writes more bytes than there are slots. Only the bench scenarios can show that the right bytes hold the right values. They cover the two address forms across sectors, lowest-index ordering, duplicate offsets, once-only application under a repeated end indication, the effect of a new sector, and the fail path with its priority. The bench does this against its own byte-RAM model and an independent expected image.

// File: rtl/ecc_patch_pkg.sv
package ecc_patch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_WRITE  = 2'd2,
    ST_FINISH = 2'd3
  } patchState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // snapshot the result bank and sector context
    logic clearDone;  // forget which slots were applied
    logic rdPhase;    // read cycle: latch the selected slot
    logic wrPhase;    // write cycle: mark the current slot applied
  } patchCtl_t;

endpackage

// File: rtl/ecc_patch_dp.sv
module ecc_patch_dp
  import ecc_patch_pkg::*;
#(
  parameter int          SLOTS     = 4,
  parameter int          OFF_W     = 9,
  parameter int          SEC_W     = 2,
  parameter int          SLOT_W    = 2,
  parameter logic [31:0] EMPTY_VAL = 32'h0000_0000,
  localparam int         ADDR_W    = OFF_W + SEC_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  patchCtl_t             ctl,
  input  logic [SLOTS*32-1:0]   resultBank,
  input  logic [SEC_W-1:0]      sectorIdx,
  input  logic                  largePage,
  input  logic [7:0]            ramRdata,
  output logic                  anyPending,
  output logic [ADDR_W-1:0]     ramAddr,
  output logic [7:0]            ramWdata
);

  logic [SLOTS-1:0][31:0] snap;
  logic [SLOTS-1:0]       liveVec;
  logic [SLOTS-1:0]       doneFlag;
  logic [SLOTS-1:0]       pendVec;
  logic [SEC_W-1:0]       secReg;
  logic                   lpReg;
  logic [SLOT_W-1:0]      curSlot;
  logic [SLOT_W-1:0]      pendIdx;
  logic [31:0]            selWord;
  logic [31:0]            curWord;

  // snapshot of the bank and the sector context at pass acceptance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snap   <= {SLOTS{EMPTY_VAL}};
      secReg <= '0;
      lpReg  <= 1'b0;
    end else if (ctl.capture) begin
      snap   <= resultBank;
      secReg <= sectorIdx;
      lpReg  <= largePage;
    end
  end

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_live
      assign liveVec[g] = (snap[g] != EMPTY_VAL);
    end
  endgenerate

  assign pendVec    = liveVec & ~doneFlag;
  assign anyPending = |pendVec;

  // lowest pending slot wins
  always_comb begin
    pendIdx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (pendVec[i]) pendIdx = i[SLOT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= '0;
      curSlot  <= '0;
    end else begin
      if (ctl.clearDone)    doneFlag <= '0;
      else if (ctl.wrPhase) doneFlag[curSlot] <= 1'b1;
      if (ctl.rdPhase)      curSlot <= pendIdx;
    end
  end

  function automatic logic [ADDR_W-1:0] buildAddr(input logic [31:0] word,
                                                  input logic lp,
                                                  input logic [SEC_W-1:0] sec);
    logic [OFF_W-1:0] off;
    off = word[16 +: OFF_W];
    return lp ? {sec, off} : {{SEC_W{1'b0}}, off};
  endfunction

  assign curWord  = snap[curSlot];
  assign selWord  = ctl.wrPhase ? curWord : snap[pendIdx];
  assign ramAddr  = buildAddr(selWord, lpReg, secReg);
  assign ramWdata = ramRdata ^ curWord[7:0];

endmodule

// File: rtl/ecc_patch_ctrl.sv
module ecc_patch_ctrl
  import ecc_patch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sectorStart,
  input  logic      decEnd,
  input  logic      decFail,
  input  logic      anyPending,
  output patchCtl_t ctl,
  output logic      busy,
  output logic      ramRe,
  output logic      ramWe,
  output logic      decClear,
  output logic      passDone,
  output logic      sectorFail
);

  patchState_t state, stateNext;
  logic        failReg, failNext;

  always_comb begin
    stateNext = state;
    failNext  = failReg;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (sectorStart) begin
          ctl.clearDone = 1'b1;
          failNext      = 1'b0;
        end else if (!failReg && decFail) begin
          failNext  = 1'b1;
          stateNext = ST_FINISH;
        end else if (!failReg && decEnd) begin
          ctl.capture = 1'b1;
          stateNext   = ST_READ;
        end
      end
      ST_READ: begin
        ctl.rdPhase = anyPending;
        stateNext   = anyPending ? ST_WRITE : ST_FINISH;
      end
      ST_WRITE: begin
        ctl.wrPhase = 1'b1;
        stateNext   = ST_READ;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      failReg <= 1'b0;
    end else begin
      state   <= stateNext;
      failReg <= failNext;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign ramRe      = (state == ST_READ) && anyPending;
  assign ramWe      = (state == ST_WRITE);
  assign decClear   = (state == ST_FINISH);
  assign passDone   = (state == ST_FINISH) && !failReg;
  assign sectorFail = failReg;

endmodule

// File: rtl/ecc_patch.sv
module ecc_patch
  import ecc_patch_pkg::*;
#(
  parameter int          SLOTS        = 4,
  parameter int          SECTOR_BYTES = 512,
  parameter int          SECTORS      = 4,
  parameter logic [31:0] EMPTY_VAL    = 32'h0000_0000,
  localparam int         OFF_W        = $clog2(SECTOR_BYTES),
  localparam int         SEC_W        = (SECTORS > 1) ? $clog2(SECTORS) : 1,
  localparam int         SLOT_W       = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int         ADDR_W       = OFF_W + SEC_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sectorStart,
  input  logic [SEC_W-1:0]    sectorIdx,
  input  logic                largePage,
  input  logic [SLOTS*32-1:0] resultBank,
  input  logic                decEnd,
  input  logic                decFail,
  output logic                decClear,
  output logic                passDone,
  output logic                sectorFail,
  output logic                busy,
  output logic                ramRe,
  output logic                ramWe,
  output logic [ADDR_W-1:0]   ramAddr,
  output logic [7:0]          ramWdata,
  input  logic [7:0]          ramRdata
);

  patchCtl_t ctl;
  logic      anyPending;

  ecc_patch_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sectorStart(sectorStart),
    .decEnd     (decEnd),
    .decFail    (decFail),
    .anyPending (anyPending),
    .ctl        (ctl),
    .busy       (busy),
    .ramRe      (ramRe),
    .ramWe      (ramWe),
    .decClear   (decClear),
    .passDone   (passDone),
    .sectorFail (sectorFail)
  );

  ecc_patch_dp #(
    .SLOTS    (SLOTS),
    .OFF_W    (OFF_W),
    .SEC_W    (SEC_W),
    .SLOT_W   (SLOT_W),
    .EMPTY_VAL(EMPTY_VAL)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .resultBank(resultBank),
    .sectorIdx (sectorIdx),
    .largePage (largePage),
    .ramRdata  (ramRdata),
    .anyPending(anyPending),
    .ramAddr   (ramAddr),
    .ramWdata  (ramWdata)
  );

endmodule

// File: rtl/ecc_patch_chk.sv
module ecc_patch_chk #(
  parameter int SLOTS  = 4,
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              decEnd,
  input logic              decFail,
  input logic              decClear,
  input logic              passDone,
  input logic              sectorFail,
  input logic              busy,
  input logic              ramRe,
  input logic              ramWe,
  input logic [ADDR_W-1:0] ramAddr
);

  logic [15:0] wrInPass;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      wrInPass <= '0;
    else if (!busy) wrInPass <= '0;
    else if (ramWe) wrInPass <= wrInPass + 16'd1;
  end

  p_we_after_re_r5: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> $past(ramRe));

  p_re_then_we_r5: assert property (@(posedge clk) disable iff (!rstN)
    ramRe |=> ramWe);

  p_same_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> ramAddr == $past(ramAddr));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!ramWe && !ramRe));

  p_start_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(decEnd || decFail));

  p_clear_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    decClear |=> !decClear);

  p_done_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    passDone |-> decClear);

  p_fail_no_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    sectorFail |-> !ramWe);

  p_fail_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(sectorFail));

  p_once_per_slot_r6: assert property (@(posedge clk) disable iff (!rstN)
    passDone |-> (wrInPass <= 16'(SLOTS)));

endmodule

bind ecc_patch ecc_patch_chk #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .decEnd    (decEnd),
  .decFail   (decFail),
  .decClear  (decClear),
  .passDone  (passDone),
  .sectorFail(sectorFail),
  .busy      (busy),
  .ramRe     (ramRe),
  .ramWe     (ramWe),
  .ramAddr   (ramAddr)
);

// File: tb/ecc_patch_tb_top.sv
module ecc_patch_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 2048;
  localparam int NVEC       = 6;

  typedef struct packed {
    logic         lp;
    logic [1:0]   sec;
    logic [127:0] bank;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'd0, {32'h0, 32'h0, 32'h0, 32'h0005_00A5}},
    '{1'b1, 2'd3, {32'h0100_00FF, 32'h0, 32'h0000_0001, 32'h01FF_0080}},
    '{1'b0, 2'd2, {32'h0040_0044, 32'h0030_0033, 32'h0020_0022, 32'h0010_0011}},
    '{1'b1, 2'd1, {32'h0, 32'h0, 32'h0, 32'h0}},
    '{1'b1, 2'd1, {32'h0, 32'h0007_00F0, 32'h0, 32'h0007_000F}},
    '{1'b0, 2'd1, {32'h0, 32'h0, 32'h0000_0055, 32'h0}}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         sectorStart = 1'b0;
  logic [1:0]   sectorIdx = '0;
  logic         largePage = 1'b0;
  logic [127:0] resultBank = '0;
  logic         decEnd = 1'b0;
  logic         decFail = 1'b0;
  logic         decClear, passDone, sectorFail, busy, ramRe, ramWe;
  logic [10:0]  ramAddr;
  logic [7:0]   ramWdata;
  logic [7:0]   ramRdata;

  logic [7:0] mem    [MEM_BYTES];
  logic [7:0] expMem [MEM_BYTES];
  int wrCount = 0;
  int doneCount = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ecc_patch dut_i (
    .clk(clk), .rstN(rstN), .sectorStart(sectorStart), .sectorIdx(sectorIdx),
    .largePage(largePage), .resultBank(resultBank), .decEnd(decEnd),
    .decFail(decFail), .decClear(decClear), .passDone(passDone),
    .sectorFail(sectorFail), .busy(busy), .ramRe(ramRe), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  // byte RAM model: one-cycle read latency
  always @(posedge clk) begin
    ramRdata <= mem[ramAddr];
    if (ramWe) begin
      mem[ramAddr] <= ramWdata;
      wrCount <= wrCount + 1;
    end
    if (passDone) doneCount <= doneCount + 1;
  end

  function automatic logic [7:0] fillByte(input int i);
    return 8'((i * 37) + (i >> 3) + 11);
  endfunction

  task automatic initMem();
    for (int i = 0; i < MEM_BYTES; i++) begin
      mem[i]    = fillByte(i);
      expMem[i] = fillByte(i);
    end
  endtask

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkMem(input string req);
    int bad = 0;
    for (int i = 0; i < MEM_BYTES; i++) if (mem[i] !== expMem[i]) bad++;
    check(req, bad, 0, "mismatching bytes");
  endtask

  // apply a bank to the expected image per R3/R4
  task automatic expectBank(input logic lp, input logic [1:0] sec,
                            input logic [127:0] bank, output int nLive);
    nLive = 0;
    for (int g = 0; g < 4; g++) begin
      logic [31:0] w;
      int a;
      w = bank[g*32 +: 32];
      if (w != 32'h0) begin
        a = lp ? (int'(sec) * 512 + int'(w[24:16])) : int'(w[24:16]);
        expMem[a] = expMem[a] ^ w[7:0];
        nLive++;
      end
    end
  endtask

  task automatic newSector();
    sectorStart = 1'b1;
    @(negedge clk);
    sectorStart = 1'b0;
  endtask

  task automatic runPass(input logic lp, input logic [1:0] sec, input logic [127:0] bank);
    largePage  = lp;
    sectorIdx  = sec;
    resultBank = bank;
    decEnd     = 1'b1;
    @(negedge clk);
    decEnd = 1'b0;
    for (int k = 0; k < 100 && busy; k++) @(negedge clk);
  endtask

  initial begin
    int w0, d0, nLive;
    initMem();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {busy, ramRe, ramWe, decClear, passDone, sectorFail}, 0, "outputs during reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {busy, ramRe, ramWe, decClear, passDone, sectorFail}, 0, "outputs after reset");

    // table walk: R2 R3 R4
    for (int v = 0; v < NVEC; v++) begin
      initMem();
      newSector();
      expectBank(VECS[v].lp, VECS[v].sec, VECS[v].bank, nLive);
      w0 = wrCount; d0 = doneCount;
      runPass(VECS[v].lp, VECS[v].sec, VECS[v].bank);
      check("R2", wrCount - w0, nLive, $sformatf("vector %0d write count", v));
      check("R3", doneCount - d0, 1, $sformatf("vector %0d pass completions", v));
      checkMem("R4");
    end

    // R5 R9 R10: exact cycle sequence, two live slots, lowest first
    initMem();
    newSector();
    largePage  = 1'b1;
    sectorIdx  = 2'd2;
    resultBank = {32'h0, 32'h0003_0011, 32'h0009_0022, 32'h0};
    decEnd     = 1'b1;
    @(negedge clk);
    decEnd = 1'b0;
    check("R5", {ramRe, ramWe}, 2'b10, "first read cycle strobes");
    check("R5", ramAddr, 1033, "first read address (slot 1)");
    decFail = 1'b1;                       // R10: ignored while busy
    @(negedge clk);
    decFail = 1'b0;
    check("R5", {ramRe, ramWe}, 2'b01, "first write cycle strobes");
    check("R3", ramWdata, fillByte(1033) ^ 8'h22, "first repaired byte");
    @(negedge clk);
    check("R5", ramAddr, 1027, "second read address (slot 2)");
    sectorStart = 1'b1;                   // R10: ignored while busy
    @(negedge clk);
    sectorStart = 1'b0;
    check("R3", ramWdata, fillByte(1027) ^ 8'h11, "second repaired byte");
    @(negedge clk);
    check("R9", {busy, ramRe, ramWe, decClear}, 4'b1000, "select cycle after last slot");
    @(negedge clk);
    check("R9", {busy, decClear, passDone}, 3'b111, "finish cycle");
    @(negedge clk);
    check("R9", {busy, decClear}, 0, "idle after finish");
    check("R10", sectorFail, 0, "decFail during pass ignored");

    // R6: repeated end with no new sector (sectorStart above was ignored)
    w0 = wrCount; d0 = doneCount;
    runPass(1'b1, 2'd2, {32'h0, 32'h0003_0011, 32'h0009_0022, 32'h0});
    check("R6", wrCount - w0, 0, "writes on repeated end");
    check("R6", doneCount - d0, 1, "repeated pass still completes");
    check("R6", mem[1033], fillByte(1033) ^ 8'h22, "byte not flipped twice");

    // R7: new sector re-arms the slots
    newSector();
    w0 = wrCount;
    runPass(1'b1, 2'd2, {32'h0, 32'h0003_0011, 32'h0009_0022, 32'h0});
    check("R7", wrCount - w0, 2, "writes after new sector");
    check("R7", mem[1027], fillByte(1027), "byte restored by second XOR");

    // R8: fail path, priority over end, end ignored afterwards
    newSector();
    w0 = wrCount; d0 = doneCount;
    largePage = 1'b1; sectorIdx = 2'd0;
    resultBank = {96'h0, 32'h0005_00A5};
    decFail = 1'b1; decEnd = 1'b1;
    @(negedge clk);
    decFail = 1'b0; decEnd = 1'b0;
    check("R8", {sectorFail, decClear, passDone}, 3'b110, "fail cycle outputs");
    @(negedge clk);
    check("R8", busy, 0, "idle after fail");
    decEnd = 1'b1;
    @(negedge clk);
    decEnd = 1'b0;
    check("R8", busy, 0, "end ignored on failed sector");
    @(negedge clk);
    check("R8", wrCount - w0, 0, "no writes on failed sector");
    check("R8", doneCount - d0, 0, "no pass completion on failed sector");
    newSector();
    check("R7", sectorFail, 0, "new sector clears fail");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule